// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers up to twelve event sources into a sticky 16-bit status word and drives one active-high interrupt line. The line is high whenever at least one status bit is set while its mask bit is clear. A mask bit that is set disables its source. Software works on the mask and the status through a byte-wide register port. It clears pending events by writing ones to two acknowledge registers.

The event sources are single-cycle set pulses. Three of them come from a real-time-clock block: the periodic tick on bit 8, the alarm on bit 9 and the update error on bit 10. A push-button level input is synchronised on chip and turned into a set of bit 11 on each rising edge. The register port has no data stream, so it has no valid/ready handshake. A write takes effect at the clock edge where `reg_wr` is high. Reads are combinational from the stored state.

Top module: `irq_status_ctrl`

## Requirements
- R1: `irq_out` is high exactly when some bit has status 1 and mask 0. It follows the stored registers combinationally, so it changes in the same cycle as the register update that causes it.
- R2: After reset the mask is 0x0FFF, the status is 0x0000 and `irq_out` is low.
- R3: Register addresses are 0 = mask bits 7:0, 1 = mask bits 15:8, 2 = status bits 7:0, 3 = status bits 15:8, 4 = acknowledge low, 5 = acknowledge high. A write to one mask half leaves the other half unchanged. `reg_rdata` shows the addressed register combinationally.
- R4: A write to address 4 clears each status bit 7:0 whose data bit is 1. A write to address 5 does the same for bits 15:8. Both acknowledge addresses read as 0x00.
- R5: Writes to the status addresses 2 and 3 have no effect. Addresses 6 and 7 read 0x00 and ignore writes.
- R6: A pulse on `evt_set[i]` sets status bit i at the next clock edge, whatever the mask. Status bits 15:12 always read zero.
- R7: When a set of a status bit and an acknowledge of that same bit fall in the same cycle, the bit ends up set.
- R8: `btn_in` passes through two synchroniser flops, and its rising edge sets status bit 11. The bit is visible after the third clock edge that samples the input high. A level held high, or a fall, sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| evt_set | input | 12 | Single-cycle event set pulses, bit i sets status bit i |
| btn_in | input | 1 | Asynchronous push-button level |
| irq_out | output | 1 | Active-high interrupt |

## Verification
The bench builds the block with its default parameters: twelve sources, the button on bit 11 and a two-stage synchroniser. With these values the unimplemented status bits 15:12 sit next to implemented ones in the high byte. This lets the bench confirm that those bits stay zero while the RTC and button bits share the same acknowledge byte. It also brings the three-edge button latency, and the collision of a button edge with an acknowledge, within reach of short directed runs and of random runs.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int BYTE_W = 8;
  localparam int STAT_W = 2 * BYTE_W;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_MASK_LO = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MASK_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_STAT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ACK_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_ACK_HI  = 3'd5;
endpackage

// File: rtl/irq_btn_edge.sv
module irq_btn_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic rise_o
);
  // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], btn_i};
  end

  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];

  // R8: a held level gives exactly one edge pulse
  a_r8_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_ctrl_pkg::*;
#(
  parameter logic [STAT_W-1:0] RST_VAL = 16'h0FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wr_half,
  input  logic [BYTE_W-1:0] wdata,
  output logic [STAT_W-1:0] mask_o
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n)          mask_o[h*BYTE_W +: BYTE_W] <= RST_VAL[h*BYTE_W +: BYTE_W];
      else if (wr_half[h]) mask_o[h*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  // R3: writing the low half keeps the high half
  a_r3_half_isolate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_half == 2'b01) |=> $stable(mask_o[STAT_W-1:BYTE_W]));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_ctrl_pkg::*;
#(
  parameter int SRC_CNT = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_CNT-1:0] set_i,
  input  logic [1:0]         ack_half,
  input  logic [BYTE_W-1:0]  ack_data,
  output logic [STAT_W-1:0]  stat_o
);
  logic [STAT_W-1:0] set_w;
  logic [STAT_W-1:0] clr_w;

  for (genvar g = 0; g < STAT_W; g++) begin : g_set
    if (g < SRC_CNT) begin : g_src
      assign set_w[g] = set_i[g];
    end else begin : g_none
      assign set_w[g] = 1'b0;
    end
  end

  assign clr_w = {(ack_half[1] ? ack_data : '0), (ack_half[0] ? ack_data : '0)};

  // set has priority over a same-cycle acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= (stat_o & ~clr_w) | set_w;
  end

  // R6 and R7: every pulsed source is set after the edge, even if acknowledged
  a_r6_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((stat_o[SRC_CNT-1:0] & $past(set_i)) == $past(set_i)));

  // R4: acknowledged bits without a new set are clear after the edge
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_half[0] |=> ((stat_o[BYTE_W-1:0] & $past(ack_data) & ~$past(set_w[BYTE_W-1:0])) == '0));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int                SRC_CNT     = 12,
  parameter int                BTN_BIT     = 11,
  parameter int                SYNC_STAGES = 2,
  parameter logic [STAT_W-1:0] MASK_RST    = 16'h0FFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [BYTE_W-1:0]  reg_wdata,
  output logic [BYTE_W-1:0]  reg_rdata,
  input  logic [SRC_CNT-1:0] evt_set,
  input  logic               btn_in,
  output logic               irq_out
);
  logic               btn_rise;
  logic [SRC_CNT-1:0] set_vec;
  logic [1:0]         mask_wr;
  logic [1:0]         ack_wr;
  logic [STAT_W-1:0]  mask_q;
  logic [STAT_W-1:0]  stat_q;

  assign mask_wr = {reg_wr && reg_addr == ADR_MASK_HI, reg_wr && reg_addr == ADR_MASK_LO};
  assign ack_wr  = {reg_wr && reg_addr == ADR_ACK_HI,  reg_wr && reg_addr == ADR_ACK_LO};

  always_comb begin
    set_vec = evt_set;
    set_vec[BTN_BIT] = evt_set[BTN_BIT] | btn_rise;
  end

  irq_btn_edge #(.STAGES(SYNC_STAGES)) u_btn (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_in), .rise_o(btn_rise)
  );

  irq_mask_reg #(.RST_VAL(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_half(mask_wr), .wdata(reg_wdata), .mask_o(mask_q)
  );

  irq_status_reg #(.SRC_CNT(SRC_CNT)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .ack_half(ack_wr),
    .ack_data(reg_wdata), .stat_o(stat_q)
  );

  always_comb begin
    case (reg_addr)
      ADR_MASK_LO: reg_rdata = mask_q[BYTE_W-1:0];
      ADR_MASK_HI: reg_rdata = mask_q[STAT_W-1:BYTE_W];
      ADR_STAT_LO: reg_rdata = stat_q[BYTE_W-1:0];
      ADR_STAT_HI: reg_rdata = stat_q[STAT_W-1:BYTE_W];
      default:     reg_rdata = '0;
    endcase
  end

  assign irq_out = |(stat_q & ~mask_q);

  // R1: a fully set mask keeps the line quiet
  a_r1_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_out);

  // R5: status writes do not change status when nothing sets or clears
  a_r5_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == ADR_STAT_LO || reg_addr == ADR_STAT_HI) && set_vec == '0)
      |=> $stable(stat_q));
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [11:0] evt_set = '0;
  logic       btn_in = 1'b0;
  logic       irq_out;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] m_mask, m_stat;
  logic h1, h2, h3;

  always #5 clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .btn_in(btn_in), .irq_out(irq_out)
  );

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_mask[7:0];
      3'd1: return m_mask[15:8];
      3'd2: return m_stat[7:0];
      3'd3: return m_stat[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |(m_stat & ~m_mask);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at time %0t", tag, act, exp, $time);
    end
  endtask

  // model of the register file, from the requirements
  task automatic model_edge(input logic [2:0] a, input logic w, input logic [7:0] d,
                            input logic [11:0] e, input logic b);
    logic [15:0] clr, setv;
    logic rise;
    rise = h2 & ~h3;
    h3 = h2; h2 = h1; h1 = b;
    clr = '0;
    if (w && a == 3'd4) clr[7:0] = d;
    if (w && a == 3'd5) clr[15:8] = d;
    setv = {4'b0, e};
    if (rise) setv[11] = 1'b1;
    m_stat = ((m_stat & ~clr) | setv) & 16'h0FFF;
    if (w && a == 3'd0) m_mask[7:0] = d;
    if (w && a == 3'd1) m_mask[15:8] = d;
  endtask

  task automatic step(input logic [2:0] a, input logic w, input logic [7:0] d,
                      input logic [11:0] e, input logic b, input string tag);
    @(negedge clk);
    reg_addr = a; reg_wr = w; reg_wdata = d; evt_set = e; btn_in = b;
    @(posedge clk);
    model_edge(a, w, d, e, b);
    #2;
    check({tag, " R1 irq"}, {15'b0, irq_out}, {15'b0, exp_irq()});
    check({tag, " read"}, {8'b0, reg_rdata}, {8'b0, exp_read(a)});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_mask = 16'h0FFF; m_stat = '0; h1 = 0; h2 = 0; h3 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R2 reset irq", {15'b0, irq_out}, 16'h0);
    // R2: reset values through the register port
    for (int a = 0; a < 6; a++) step(3'(a), 1'b0, 8'h00, '0, 1'b0, "R2");

    // R3: halves are independent
    step(3'd0, 1'b1, 8'h00, '0, 1'b0, "R3");
    step(3'd1, 1'b0, 8'h00, '0, 1'b0, "R3");
    // R6: source 3 set, unmasked
    step(3'd2, 1'b0, 8'h00, 12'h008, 1'b0, "R6");
    step(3'd0, 1'b1, 8'h08, '0, 1'b0, "R1");
    // R5: status writes ignored
    step(3'd2, 1'b1, 8'h00, '0, 1'b0, "R5");
    step(3'd3, 1'b1, 8'hFF, '0, 1'b0, "R5");
    // R4: acknowledge clears, reads zero
    step(3'd4, 1'b1, 8'h08, '0, 1'b0, "R4");
    step(3'd2, 1'b0, 8'h00, '0, 1'b0, "R4");
    // R6: RTC tick while masked, then unmask
    step(3'd3, 1'b0, 8'h00, 12'h100, 1'b0, "R6");
    step(3'd1, 1'b1, 8'h00, '0, 1'b0, "R1");
    // R7: set and acknowledge collide
    step(3'd5, 1'b1, 8'h01, 12'h100, 1'b0, "R7");
    step(3'd3, 1'b0, 8'h00, '0, 1'b0, "R7");
    step(3'd5, 1'b1, 8'h01, '0, 1'b0, "R4");
    // R8: rising edge, held high, acknowledge, no retrigger, second edge
    for (int i = 0; i < 4; i++) step(3'd3, 1'b0, 8'h00, '0, 1'b1, "R8");
    step(3'd5, 1'b1, 8'h08, '0, 1'b1, "R8");
    for (int i = 0; i < 5; i++) step(3'd3, 1'b0, 8'h00, '0, 1'b1, "R8");
    for (int i = 0; i < 4; i++) step(3'd3, 1'b0, 8'h00, '0, 1'b0, "R8");
    for (int i = 0; i < 4; i++) step(3'd3, 1'b0, 8'h00, '0, 1'b1, "R8");
    // R5: unmapped addresses
    step(3'd6, 1'b1, 8'hFF, '0, 1'b1, "R5");
    step(3'd7, 1'b1, 8'hFF, '0, 1'b1, "R5");
    step(3'd1, 1'b0, 8'h00, '0, 1'b1, "R5");

    // random mix covering R1 R3 R4 R6 R7 R8
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      logic w;
      logic b;
      a = 3'($urandom_range(0, 7));
      w = ($urandom_range(0, 3) != 0);
      b = (($urandom_range(0, 7)) == 0) ? ~btn_in : btn_in;
      step(a, w, 8'($urandom), 12'($urandom & $urandom & $urandom), b, "RND");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule